// File: doc/BRIEF.md
# Reset-Time Boot Source Selector

This block chooses where code execution begins once the chip leaves reset: the user application vector or the boot loader entry. The choice is made only once per reset, at the moment the synchronised reset input falls. It combines a stored status byte with three strap pins: the fetch strobe (active low), the external-access pin and the address latch pin. A nonzero status byte, or the strap combination fetch-low, external-access-high, latch-high, selects the loader. Otherwise execution begins at the user vector.

The block also models the nonvolatile configuration that the decision depends on. That storage holds the status byte, three security bits and the clock-mode bit. Each stored field can move in one direction only, by a program strobe. Only a full erase strobe returns all of them to their factory values. A separate power-on input stands for the factory-erased state of the storage. The chip reset pin never touches the storage. All ports are plain control and status pins. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `boot_src_sel`

## Requirements
- R1: While `por_n` is low, and after it is released with no other activity, `status_rd` is FFh, `sec_rd` is 000b, `clk6_rd` is 0, `boot_mode` is 0, `start_addr` equals `USER_VEC` (0000h) and `decide_pulse` is 0.
- R2: A decision is taken only on a falling edge of `rst_pin`. Its result appears on the third rising clock edge after the fall, together with a `decide_pulse` that lasts exactly one cycle. At all other times `boot_mode` and `start_addr` hold their values, whatever the straps and the stored byte do.
- R3: If the stored status byte is 00h and the straps do not force the loader, the decision gives `boot_mode` = 0 and `start_addr` = `USER_VEC` (0000h).
- R4: If the stored status byte is any nonzero value, the decision gives `boot_mode` = 1 and `start_addr` = `LOADER_VEC` (FC00h).
- R5: The straps `strap_fetch_n` = 0, `strap_ext_access` = 1 and `strap_latch_en` = 1, sampled together at the decision, force `boot_mode` = 1 even when the status byte is 00h. Every other strap combination leaves the choice to the status byte.
- R6: A `prog_status_stb` cycle makes `status_rd` read 00h from the next cycle on. Once the byte is 00h, it stays 00h until an erase, whatever else is strobed.
- R7: An `erase_stb` cycle makes `status_rd` read FFh, `sec_rd` read 000b and `clk6_rd` read 0 (12-clock mode) on the next cycle. Erase wins over any program strobe in the same cycle.
- R8: A `prog_sec_stb` cycle with `prog_sec_sel` equal to 0, 1 or 2 sets bit 0, 1 or 2 of `sec_rd` on the next cycle. The select value 3 changes nothing. Security bits stay set until an erase.
- R9: A `prog_clk6_stb` cycle sets `clk6_rd` to 1 (6-clock mode) on the next cycle. The bit stays set until an erase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, active low; models the factory-erased storage |
| rst_pin | input | 1 | Chip reset, active high, asynchronous; its fall triggers the decision |
| strap_fetch_n | input | 1 | Fetch strobe strap, active low |
| strap_ext_access | input | 1 | External-access strap |
| strap_latch_en | input | 1 | Address latch strap |
| prog_status_stb | input | 1 | Program the status byte to 00h |
| prog_sec_stb | input | 1 | Program the security bit chosen by `prog_sec_sel` |
| prog_sec_sel | input | 2 | Security bit index (0..2; 3 is ignored) |
| prog_clk6_stb | input | 1 | Program the clock-mode bit to 6-clock |
| erase_stb | input | 1 | Full erase of all stored fields |
| status_rd | output | 8 | Stored status byte readback |
| sec_rd | output | 3 | Security bits readback |
| clk6_rd | output | 1 | Clock-mode bit readback (1 = 6-clock) |
| boot_mode | output | 1 | 1 = boot loader selected |
| start_addr | output | 16 | Execution start address |
| decide_pulse | output | 1 | One-cycle pulse when a new decision is taken |

## Verification
A storage strobe held across one rising edge is due on the readback ports at that same edge. The bench releases each strobe and checks the readback at the next falling edge. A fall of `rst_pin` crosses two synchroniser flops and one decision register, so the decision is due on the third rising edge. The bench checks that the outputs still hold their old values after the second edge, checks the new value and the pulse after the third, and checks that the pulse has gone after the fourth. Strap and storage changes are made between decisions. The held outputs are then checked at the next falling edge to show that those changes were ignored.

// File: rtl/boot_sel_pkg.sv
`timescale 1ns/1ps
package boot_sel_pkg;
  localparam int STATUS_W = 8;
  localparam int SEC_BITS = 3;
  localparam int SEC_SEL_W = $clog2(SEC_BITS + 1);
  localparam logic [STATUS_W-1:0] STATUS_ERASED = '1;
  localparam logic [STATUS_W-1:0] STATUS_RUN    = '0;

  typedef struct packed {
    logic [STATUS_W-1:0] status;
    logic [SEC_BITS-1:0] sec;
    logic                clk6;
  } nv_state_t;

  function automatic logic straps_force(input logic fetch_n, input logic ext_acc, input logic latch_en);
    return !fetch_n && ext_acc && latch_en;
  endfunction
endpackage

// File: rtl/boot_rst_sync.sv
`timescale 1ns/1ps
module boot_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  input  logic rst_pin,
  output logic rst_fall
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= rst_pin;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) sync_q <= '1;
        else        sync_q <= {sync_q[STAGES-2:0], rst_pin};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) prev_q <= 1'b1;
    else        prev_q <= sync_q[STAGES-1];
  end

  assign rst_fall = prev_q && !sync_q[STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
    rst_fall |=> !rst_fall); // R2
endmodule

// File: rtl/boot_nv_store.sv
`timescale 1ns/1ps
module boot_nv_store
  import boot_sel_pkg::*;
(
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 prog_status_stb,
  input  logic                 prog_sec_stb,
  input  logic [SEC_SEL_W-1:0] prog_sec_sel,
  input  logic                 prog_clk6_stb,
  input  logic                 erase_stb,
  output nv_state_t            state_q
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               state_q.status <= STATUS_ERASED;
    else if (erase_stb)       state_q.status <= STATUS_ERASED;
    else if (prog_status_stb) state_q.status <= STATUS_RUN;
  end

  generate
    for (genvar i = 0; i < SEC_BITS; i++) begin : g_sec
      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n)         state_q.sec[i] <= 1'b0;
        else if (erase_stb) state_q.sec[i] <= 1'b0;
        else if (prog_sec_stb && prog_sec_sel == SEC_SEL_W'(i))
                            state_q.sec[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             state_q.clk6 <= 1'b0;
    else if (erase_stb)     state_q.clk6 <= 1'b0;
    else if (prog_clk6_stb) state_q.clk6 <= 1'b1;
  end

  AST_PROG_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (prog_status_stb && !erase_stb) |=> state_q.status == STATUS_RUN); // R6
  AST_ZERO_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (state_q.status == STATUS_RUN && !erase_stb) |=> state_q.status == STATUS_RUN); // R6
  AST_ERASE_DEFAULT: assert property (@(posedge clk) disable iff (!por_n)
    erase_stb |=> (state_q.status == STATUS_ERASED && state_q.sec == '0 && !state_q.clk6)); // R7
  AST_SEC_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    !erase_stb |=> ((state_q.sec & $past(state_q.sec)) == $past(state_q.sec))); // R8
  AST_CLK6_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (state_q.clk6 && !erase_stb) |=> state_q.clk6); // R9
endmodule

// File: rtl/boot_decide.sv
`timescale 1ns/1ps
module boot_decide
  import boot_sel_pkg::*;
#(
  parameter int              ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] USER_VEC   = '0,
  parameter logic [ADDR_W-1:0] LOADER_VEC = 16'hFC00
) (
  input  logic                clk,
  input  logic                por_n,
  input  logic                rst_fall,
  input  logic [STATUS_W-1:0] status,
  input  logic                force_loader,
  output logic                boot_mode,
  output logic [ADDR_W-1:0]   start_addr,
  output logic                decide_pulse
);
  logic pick_loader;
  assign pick_loader = (status != STATUS_RUN) || force_loader;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      boot_mode    <= 1'b0;
      start_addr   <= USER_VEC;
      decide_pulse <= 1'b0;
    end else begin
      decide_pulse <= rst_fall;
      if (rst_fall) begin
        boot_mode  <= pick_loader;
        start_addr <= pick_loader ? LOADER_VEC : USER_VEC;
      end
    end
  end

  AST_HOLD_BETWEEN: assert property (@(posedge clk) disable iff (!por_n)
    !rst_fall |=> ($stable(boot_mode) && $stable(start_addr))); // R2
  AST_NONZERO_LOADER: assert property (@(posedge clk) disable iff (!por_n)
    (rst_fall && status != STATUS_RUN) |=> (boot_mode && start_addr == LOADER_VEC)); // R4
  AST_FORCE_LOADER: assert property (@(posedge clk) disable iff (!por_n)
    (rst_fall && force_loader) |=> boot_mode); // R5
endmodule

// File: rtl/boot_src_sel.sv
`timescale 1ns/1ps
module boot_src_sel
  import boot_sel_pkg::*;
#(
  parameter int                ADDR_W      = 16,
  parameter logic [ADDR_W-1:0] USER_VEC    = '0,
  parameter logic [ADDR_W-1:0] LOADER_VEC  = 16'hFC00,
  parameter int                SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 por_n,
  input  logic                 rst_pin,
  input  logic                 strap_fetch_n,
  input  logic                 strap_ext_access,
  input  logic                 strap_latch_en,
  input  logic                 prog_status_stb,
  input  logic                 prog_sec_stb,
  input  logic [SEC_SEL_W-1:0] prog_sec_sel,
  input  logic                 prog_clk6_stb,
  input  logic                 erase_stb,
  output logic [STATUS_W-1:0]  status_rd,
  output logic [SEC_BITS-1:0]  sec_rd,
  output logic                 clk6_rd,
  output logic                 boot_mode,
  output logic [ADDR_W-1:0]    start_addr,
  output logic                 decide_pulse
);
  logic      rst_fall;
  logic      force_loader;
  nv_state_t nv_q;

  assign force_loader = straps_force(strap_fetch_n, strap_ext_access, strap_latch_en);

  boot_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .por_n    (por_n),
    .rst_pin  (rst_pin),
    .rst_fall (rst_fall)
  );

  boot_nv_store u_store (
    .clk             (clk),
    .por_n           (por_n),
    .prog_status_stb (prog_status_stb),
    .prog_sec_stb    (prog_sec_stb),
    .prog_sec_sel    (prog_sec_sel),
    .prog_clk6_stb   (prog_clk6_stb),
    .erase_stb       (erase_stb),
    .state_q         (nv_q)
  );

  boot_decide #(
    .ADDR_W     (ADDR_W),
    .USER_VEC   (USER_VEC),
    .LOADER_VEC (LOADER_VEC)
  ) u_decide (
    .clk          (clk),
    .por_n        (por_n),
    .rst_fall     (rst_fall),
    .status       (nv_q.status),
    .force_loader (force_loader),
    .boot_mode    (boot_mode),
    .start_addr   (start_addr),
    .decide_pulse (decide_pulse)
  );

  assign status_rd = nv_q.status;
  assign sec_rd    = nv_q.sec;
  assign clk6_rd   = nv_q.clk6;

  AST_USER_VECTOR: assert property (@(posedge clk) disable iff (!por_n)
    (rst_fall && nv_q.status == STATUS_RUN && !force_loader)
      |=> (!boot_mode && start_addr == USER_VEC)); // R3
  AST_PULSE_WITH_FALL: assert property (@(posedge clk) disable iff (!por_n)
    decide_pulse |-> $past(rst_fall)); // R2
endmodule

// File: tb/boot_src_sel_tb_top.sv
`timescale 1ns/1ps
module boot_src_sel_tb_top;
  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic        rst_pin = 1'b1;
  logic        strap_fetch_n = 1'b1, strap_ext_access = 1'b0, strap_latch_en = 1'b0;
  logic        prog_status_stb = 1'b0, prog_sec_stb = 1'b0, prog_clk6_stb = 1'b0, erase_stb = 1'b0;
  logic [1:0]  prog_sec_sel = 2'd0;
  logic [7:0]  status_rd;
  logic [2:0]  sec_rd;
  logic        clk6_rd, boot_mode, decide_pulse;
  logic [15:0] start_addr;

  int checks = 0;
  int errors = 0;
  logic [7:0] m_status = 8'hFF;
  logic [2:0] m_sec = 3'b000;
  logic       m_clk6 = 1'b0;
  logic       m_boot = 1'b0;

  localparam logic [15:0] USER_A   = 16'h0000;
  localparam logic [15:0] LOADER_A = 16'hFC00;

  always #4 clk = ~clk;

  boot_src_sel dut_i (
    .clk(clk), .por_n(por_n), .rst_pin(rst_pin),
    .strap_fetch_n(strap_fetch_n), .strap_ext_access(strap_ext_access), .strap_latch_en(strap_latch_en),
    .prog_status_stb(prog_status_stb), .prog_sec_stb(prog_sec_stb), .prog_sec_sel(prog_sec_sel),
    .prog_clk6_stb(prog_clk6_stb), .erase_stb(erase_stb),
    .status_rd(status_rd), .sec_rd(sec_rd), .clk6_rd(clk6_rd),
    .boot_mode(boot_mode), .start_addr(start_addr), .decide_pulse(decide_pulse)
  );

  function automatic logic exp_loader(input logic [7:0] st, input logic fn, input logic ea, input logic le);
    return (st != 8'h00) || (!fn && ea && le);
  endfunction

  function automatic logic [15:0] exp_addr(input logic ld);
    return ld ? LOADER_A : USER_A;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_store(input string req);
    chk(req, {24'd0, status_rd}, {24'd0, m_status});
    chk(req, {29'd0, sec_rd}, {29'd0, m_sec});
    chk(req, {31'd0, clk6_rd}, {31'd0, m_clk6});
  endtask

  task automatic cmd(input bit ps, input bit sc, input logic [1:0] sel,
                     input bit ck, input bit er, input string req);
    @(negedge clk);
    prog_status_stb = ps; prog_sec_stb = sc; prog_sec_sel = sel;
    prog_clk6_stb = ck; erase_stb = er;
    @(posedge clk);
    if (er) begin
      m_status = 8'hFF; m_sec = 3'b000; m_clk6 = 1'b0;
    end else begin
      if (ps) m_status = 8'h00;
      if (sc && sel != 2'd3) m_sec[sel] = 1'b1;
      if (ck) m_clk6 = 1'b1;
    end
    @(negedge clk);
    prog_status_stb = 0; prog_sec_stb = 0; prog_clk6_stb = 0; erase_stb = 0;
    check_store(req);
    chk("R2 hold after command", {31'd0, boot_mode}, {31'd0, m_boot});
  endtask

  task automatic do_reset(input logic fn, input logic ea, input logic le, input string req);
    logic nb;
    @(negedge clk);
    rst_pin = 1'b1;
    repeat (3) @(negedge clk);
    strap_fetch_n = fn; strap_ext_access = ea; strap_latch_en = le;
    nb = exp_loader(m_status, fn, ea, le);
    @(negedge clk);
    rst_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 no early decision", {31'd0, boot_mode}, {31'd0, m_boot});
    chk("R2 no early pulse", {31'd0, decide_pulse}, 32'd0);
    @(negedge clk);
    m_boot = nb;
    chk(req, {31'd0, boot_mode}, {31'd0, nb});
    chk(req, {16'd0, start_addr}, {16'd0, exp_addr(nb)});
    chk("R2 pulse on decision", {31'd0, decide_pulse}, 32'd1);
    strap_fetch_n = ~fn; strap_ext_access = ~ea; strap_latch_en = ~le;
    @(negedge clk);
    chk("R2 pulse one cycle", {31'd0, decide_pulse}, 32'd0);
    chk("R2 straps ignored", {31'd0, boot_mode}, {31'd0, nb});
    chk("R2 straps ignored", {16'd0, start_addr}, {16'd0, exp_addr(nb)});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = 32'h5EED_1234;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R1 reset boot_mode", {31'd0, boot_mode}, 32'd0);
    chk("R1 reset start_addr", {16'd0, start_addr}, {16'd0, USER_A});
    check_store("R1 reset storage");
    por_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 idle after release", {31'd0, decide_pulse}, 32'd0);
    check_store("R1 idle storage");

    do_reset(1'b1, 1'b0, 1'b0, "R4 erased byte selects loader");
    cmd(1, 0, 2'd0, 0, 0, "R6 program clears byte");
    do_reset(1'b1, 1'b1, 1'b1, "R3 zero byte selects user vector");
    do_reset(1'b0, 1'b1, 1'b1, "R5 strap force");
    do_reset(1'b0, 1'b0, 1'b1, "R5 partial strap no force");
    do_reset(1'b0, 1'b1, 1'b0, "R5 partial strap no force");
    cmd(0, 1, 2'd3, 0, 0, "R8 select 3 ignored");
    cmd(0, 1, 2'd1, 0, 0, "R8 set bit 1");
    cmd(0, 0, 2'd0, 1, 0, "R9 clock mode set");
    cmd(1, 0, 2'd0, 0, 0, "R6 program again stays zero");
    cmd(1, 1, 2'd2, 1, 1, "R7 erase wins");
    do_reset(1'b1, 1'b1, 1'b1, "R4 erased byte after erase");
    cmd(0, 1, 2'd0, 0, 0, "R8 set bit 0");
    cmd(0, 1, 2'd2, 0, 0, "R8 set bit 2");
    cmd(0, 0, 2'd0, 0, 1, "R7 erase clears all");

    for (int i = 0; i < 60; i++) begin
      int unsigned r;
      r = $urandom % 8;
      if (r < 2) begin
        do_reset(1'($urandom), 1'($urandom), 1'($urandom), "R3/R4/R5 random decision");
      end else if (r == 2) begin
        do_reset(1'b0, 1'b1, 1'b1, "R5 random force");
      end else begin
        cmd(1'($urandom % 3 == 0), 1'($urandom), 2'($urandom), 1'($urandom % 4 == 0),
            1'($urandom % 6 == 0), "R6/R7/R8/R9 random command");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule